// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This block keeps two small caches coherent on one shared bus. Each cache holds a few one-word lines, and every line is Invalid, Shared or Dirty. A processor port per cache presents read or write requests to one line. Hits complete in the same cycle without touching the bus. Misses and ownership upgrades compete for the bus, and the block grants one transaction per cycle. That transaction is either a data fetch or an invalidate broadcast. The other cache snoops it in the same cycle.

The scheme has three states and no exclusive-clean state. A write from Invalid or Shared always broadcasts an invalidate. A fetch that finds the other cache holding the line Dirty makes that cache flush the word to the backing memory and drop to Shared. The requester receives the flushed word as its fill. The backing memory has one word per line index and is modelled inside the block.

A request stays valid until its done pulse. The block asserts done combinationally in the cycle the request completes.

Top module: `coh_top`

## Requirements
- R1: After reset every line of both caches is Invalid. The state encoding is Invalid=0, Shared=1, Dirty=2, and cache c line l appears at `line_state_o[(c*NUM_LINES+l)*2 +: 2]`. Backing memory resets to zero.
- R2: A read of an Invalid line issues a fetch (`bus_cmd_o`=0) when granted. It completes in that cycle with the current value of the word: the flushed word if the other cache held it Dirty, otherwise the memory word. The line becomes Shared.
- R3: A read of a Shared or Dirty line completes in the cycle it is presented, returns the cached word and uses no bus transaction.
- R4: A write to an Invalid or Shared line issues an invalidate (`bus_cmd_o`=1) when granted. It completes in that cycle and leaves the line Dirty, holding the written word.
- R5: A write to a Dirty line completes in the cycle it is presented, with no bus transaction, and the line stays Dirty.
- R6: An invalidate from one cache moves the other cache's copy of that line to Invalid.
- R7: A fetch that finds the other cache's copy Dirty raises `flush_o` in that cycle with the line index and the current word. The word is written to memory, and the flushing copy becomes Shared.
- R8: When a snooped transaction and a local request address the same line in one cycle, the snoop is applied first. The local request is then judged against the updated state, so a hit that the snoop destroys does not complete in that cycle.
- R9: At most one bus transaction occurs per cycle, and it belongs to a requesting cache, which completes in that cycle. When both caches need the bus, the preferred cache wins. After any grant the other cache becomes preferred. Cache 0 is preferred after reset.
- R10: A line is never Dirty in one cache while the other cache holds it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 2 | Request valid, one bit per cache |
| req_write_i | input | 2 | 1 = write, 0 = read, per cache |
| req_line_i | input | 2*LINE_W | Line index per cache, cache c at bits c*LINE_W |
| req_wdata_i | input | 2*DATA_W | Write word per cache |
| req_done_o | output | 2 | Request completes this cycle |
| rd_data_o | output | 2*DATA_W | Read word per cache, valid with done on a read |
| line_state_o | output | 4*NUM_LINES | Registered state of every line |
| bus_valid_o | output | 1 | A bus transaction occurs this cycle |
| bus_owner_o | output | 1 | Cache issuing the transaction |
| bus_cmd_o | output | 1 | 0 = fetch, 1 = invalidate |
| bus_line_o | output | LINE_W | Line addressed on the bus |
| flush_o | output | 1 | Dirty word written back this cycle |
| flush_line_o | output | LINE_W | Line being written back |
| flush_data_o | output | DATA_W | Word being written back |

## Verification
A bus transaction and the other cache's own request can meet on the same line in one cycle. The snoop must then act before the local hit check. The bench provokes this in two ways. One cache upgrades a Shared line while the other reads it. Then one cache writes its Dirty line while the other issues an invalidate to it. A reference model applies the snoop first and then judges the local request. The bench compares done, read data, bus and flush fields and all line states against that model on every cycle, through these directed cases and a long random mix of colliding traffic.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_DRT = 2'd2
  } line_st_e;

  typedef enum logic {
    CMD_FETCH = 1'b0,
    CMD_INVAL = 1'b1
  } bus_cmd_e;
endpackage

// File: rtl/coh_line_fsm.sv
module coh_line_fsm
  import coh_pkg::*;
(
  input  line_st_e cur_i,
  input  logic     snp_i,
  input  bus_cmd_e snp_cmd_i,
  input  logic     sel_i,
  input  logic     wr_i,
  input  logic     gnt_i,
  output line_st_e nxt_o,
  output logic     need_o,
  output logic     hit_o,
  output logic     flush_o
);
  line_st_e mid;

  // snoop first, local request judged on the result
  always_comb begin
    mid     = cur_i;
    flush_o = 1'b0;
    if (snp_i) begin
      if (snp_cmd_i == CMD_INVAL) begin
        mid = ST_INV;
      end else if (cur_i == ST_DRT) begin
        mid     = ST_SHR;
        flush_o = 1'b1;
      end
    end
    need_o = sel_i & (wr_i ? (cur_i != ST_DRT) : (cur_i == ST_INV));
    hit_o  = sel_i & ~gnt_i & (wr_i ? (mid == ST_DRT) : (mid != ST_INV));
    nxt_o  = mid;
    if (sel_i & gnt_i) nxt_o = wr_i ? ST_DRT : ST_SHR;
  end
endmodule

// File: rtl/coh_rr_arb.sv
module coh_rr_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] need_i,
  output logic [1:0] gnt_o
);
  logic prio_q;

  always_comb begin
    gnt_o = need_i;
    if (&need_i) begin
      gnt_o         = 2'b00;
      gnt_o[prio_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prio_q <= 1'b0;
    else if (|gnt_o) prio_q <= gnt_o[0];
  end
endmodule

// File: rtl/coh_cache.sv
module coh_cache
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 8,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [LINE_W-1:0]      req_line_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  input  logic                   gnt_i,
  input  logic                   snp_valid_i,
  input  bus_cmd_e               snp_cmd_i,
  input  logic [LINE_W-1:0]      snp_line_i,
  input  logic [DATA_W-1:0]      fill_data_i,
  output logic                   need_o,
  output logic                   done_o,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   flush_o,
  output logic [DATA_W-1:0]      flush_data_o,
  output logic [2*NUM_LINES-1:0] state_o
);
  logic [NUM_LINES-1:0]             need_l, hit_l, flush_l;
  logic [NUM_LINES-1:0][DATA_W-1:0] dat_all;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    line_st_e          st_q, nxt;
    logic [DATA_W-1:0] dat_q;
    logic              sel, snp;

    assign sel = req_valid_i && (req_line_i == LINE_W'(l));
    assign snp = snp_valid_i && (snp_line_i == LINE_W'(l));

    coh_line_fsm u_fsm (
      .cur_i    (st_q),
      .snp_i    (snp),
      .snp_cmd_i(snp_cmd_i),
      .sel_i    (sel),
      .wr_i     (req_write_i),
      .gnt_i    (gnt_i),
      .nxt_o    (nxt),
      .need_o   (need_l[l]),
      .hit_o    (hit_l[l]),
      .flush_o  (flush_l[l])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= ST_INV;
        dat_q <= '0;
      end else begin
        st_q <= nxt;
        if (sel && gnt_i && !req_write_i)                 dat_q <= fill_data_i;
        else if (sel && req_write_i && (gnt_i || hit_l[l])) dat_q <= req_wdata_i;
      end
    end

    assign dat_all[l]       = dat_q;
    assign state_o[2*l +: 2] = st_q;
  end

  assign need_o       = |need_l;
  assign done_o       = gnt_i | (|hit_l);
  assign rd_data_o    = (gnt_i && !req_write_i) ? fill_data_i : dat_all[req_line_i];
  assign flush_o      = |flush_l;
  assign flush_data_o = dat_all[snp_line_i];
endmodule

// File: rtl/coh_top.sv
module coh_top
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 8,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             req_valid_i,
  input  logic [1:0]             req_write_i,
  input  logic [2*LINE_W-1:0]    req_line_i,
  input  logic [2*DATA_W-1:0]    req_wdata_i,
  output logic [1:0]             req_done_o,
  output logic [2*DATA_W-1:0]    rd_data_o,
  output logic [4*NUM_LINES-1:0] line_state_o,
  output logic                   bus_valid_o,
  output logic                   bus_owner_o,
  output logic                   bus_cmd_o,
  output logic [LINE_W-1:0]      bus_line_o,
  output logic                   flush_o,
  output logic [LINE_W-1:0]      flush_line_o,
  output logic [DATA_W-1:0]      flush_data_o
);
  localparam int NUM_CACHES = 2;

  logic [NUM_CACHES-1:0]             need_c, gnt_c, flush_c;
  logic [NUM_CACHES-1:0][DATA_W-1:0] fdat_c;
  logic [NUM_LINES-1:0][DATA_W-1:0]  mem_q;
  logic [DATA_W-1:0]                 fill;

  coh_rr_arb u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .need_i(need_c),
    .gnt_o (gnt_c)
  );

  assign bus_valid_o  = |gnt_c;
  assign bus_owner_o  = gnt_c[1];
  assign bus_line_o   = req_line_i[bus_owner_o*LINE_W +: LINE_W];
  assign bus_cmd_o    = bus_valid_o & req_write_i[bus_owner_o];
  assign flush_o      = |flush_c;
  assign flush_line_o = bus_line_o;
  assign flush_data_o = flush_c[1] ? fdat_c[1] : fdat_c[0];
  assign fill         = flush_o ? flush_data_o : mem_q[bus_line_o];

  for (genvar c = 0; c < NUM_CACHES; c++) begin : g_cache
    coh_cache #(
      .NUM_LINES(NUM_LINES),
      .DATA_W   (DATA_W),
      .LINE_W   (LINE_W)
    ) u_cache (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_valid_i (req_valid_i[c]),
      .req_write_i (req_write_i[c]),
      .req_line_i  (req_line_i[c*LINE_W +: LINE_W]),
      .req_wdata_i (req_wdata_i[c*DATA_W +: DATA_W]),
      .gnt_i       (gnt_c[c]),
      .snp_valid_i (bus_valid_o & ~gnt_c[c]),
      .snp_cmd_i   (bus_cmd_e'(bus_cmd_o)),
      .snp_line_i  (bus_line_o),
      .fill_data_i (fill),
      .need_o      (need_c[c]),
      .done_o      (req_done_o[c]),
      .rd_data_o   (rd_data_o[c*DATA_W +: DATA_W]),
      .flush_o     (flush_c[c]),
      .flush_data_o(fdat_c[c]),
      .state_o     (line_state_o[c*2*NUM_LINES +: 2*NUM_LINES])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mem_q <= '0;
    else if (flush_o) mem_q[bus_line_o] <= flush_data_o;
  end
endmodule

// File: rtl/coh_chk.sv
module coh_chk #(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 8,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             req_valid_i,
  input logic [1:0]             req_write_i,
  input logic [2*LINE_W-1:0]    req_line_i,
  input logic [2*DATA_W-1:0]    req_wdata_i,
  input logic [1:0]             req_done_o,
  input logic [2*DATA_W-1:0]    rd_data_o,
  input logic [4*NUM_LINES-1:0] line_state_o,
  input logic                   bus_valid_o,
  input logic                   bus_owner_o,
  input logic                   bus_cmd_o,
  input logic [LINE_W-1:0]      bus_line_o,
  input logic                   flush_o,
  input logic [LINE_W-1:0]      flush_line_o,
  input logic [DATA_W-1:0]      flush_data_o
);
  function automatic logic [1:0] st_of(logic [4*NUM_LINES-1:0] s, logic c, logic [LINE_W-1:0] l);
    return s[(int'(c)*NUM_LINES + int'(l))*2 +: 2];
  endfunction

  function automatic logic excl_ok(logic [4*NUM_LINES-1:0] s);
    for (int l = 0; l < NUM_LINES; l++) begin
      if ((s[2*l +: 2] == 2'd2 && s[(NUM_LINES+l)*2 +: 2] != 2'd0) ||
          (s[(NUM_LINES+l)*2 +: 2] == 2'd2 && s[2*l +: 2] != 2'd0)) return 1'b0;
    end
    return 1'b1;
  endfunction

  assert_dirty_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excl_ok(line_state_o));

  assert_owner_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (req_valid_i[bus_owner_o] && req_done_o[bus_owner_o]));

  assert_flush_on_fetch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (bus_valid_o && !bus_cmd_o && flush_line_o == bus_line_o));

  assert_flush_shared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> st_of(line_state_o, !$past(bus_owner_o), $past(bus_line_o)) == 2'd1);

  assert_inval_snoop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_cmd_o) |=> st_of(line_state_o, !$past(bus_owner_o), $past(bus_line_o)) == 2'd0);

  assert_write_dirty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_cmd_o) |=> st_of(line_state_o, $past(bus_owner_o), $past(bus_line_o)) == 2'd2);

  assert_fetch_shared_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_cmd_o) |=> st_of(line_state_o, $past(bus_owner_o), $past(bus_line_o)) == 2'd1);

  for (genvar i = 0; i < 2*NUM_LINES; i++) begin : g_quiet
    assert_dirty_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_state_o[2*i +: 2] == 2'd2 && !bus_valid_o) |=> line_state_o[2*i +: 2] == 2'd2);
  end
endmodule

bind coh_top coh_chk #(
  .NUM_LINES(NUM_LINES),
  .DATA_W   (DATA_W),
  .LINE_W   (LINE_W)
) u_chk (.*);

// File: tb/sim_coh_top.sv
module sim_coh_top;
  localparam int NL = 4;
  localparam int DW = 8;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]      req_valid = '0, req_write = '0;
  logic [2*LW-1:0] req_line = '0;
  logic [2*DW-1:0] req_wdata = '0;
  logic [1:0]      req_done;
  logic [2*DW-1:0] rd_data;
  logic [4*NL-1:0] line_state;
  logic            bus_valid, bus_owner, bus_cmd, flush;
  logic [LW-1:0]   bus_line, flush_line;
  logic [DW-1:0]   flush_data;

  coh_top #(.NUM_LINES(NL), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_line_i(req_line), .req_wdata_i(req_wdata),
    .req_done_o(req_done), .rd_data_o(rd_data), .line_state_o(line_state),
    .bus_valid_o(bus_valid), .bus_owner_o(bus_owner), .bus_cmd_o(bus_cmd),
    .bus_line_o(bus_line), .flush_o(flush), .flush_line_o(flush_line),
    .flush_data_o(flush_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done_run = 0;

  bit          sv[2], sw[2];
  int          sl[2];
  logic [DW-1:0] sd[2];

  int          mst[2][NL];
  logic [DW-1:0] mdat[2][NL];
  logic [DW-1:0] mmem[NL];
  int          mrr = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int st_dut(int c, int l);
    return int'(line_state[(c*NL+l)*2 +: 2]);
  endfunction

  task automatic issue(int k, bit w, int l, logic [DW-1:0] d);
    sv[k] = 1; sw[k] = w; sl[k] = l; sd[k] = d;
  endtask

  task automatic step();
    bit need[2], e_done[2], e_bv, e_fl, e_bc;
    int g, o, ln, e_bo, e_bl;
    logic [DW-1:0] e_rd[2], e_fd, fetched;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      req_valid[k] = sv[k];
      req_write[k] = sw[k];
      req_line[k*LW +: LW] = LW'(sl[k]);
      req_wdata[k*DW +: DW] = sd[k];
    end
    #2;
    for (int c = 0; c < 2; c++)
      for (int l = 0; l < NL; l++) chk("R6", "line state", st_dut(c, l), mst[c][l]);
    for (int l = 0; l < NL; l++)
      chk("R10", "dirty exclusive",
          int'((st_dut(0,l)==2 && st_dut(1,l)!=0) || (st_dut(1,l)==2 && st_dut(0,l)!=0)), 0);
    // reference model: bus winner, snoop, then local hits
    for (int k = 0; k < 2; k++) begin
      need[k] = sv[k] && (sw[k] ? mst[k][sl[k]] != 2 : mst[k][sl[k]] == 0);
      e_done[k] = 0; e_rd[k] = '0;
    end
    g = -1;
    if (need[0] && need[1]) g = mrr;
    else if (need[0]) g = 0;
    else if (need[1]) g = 1;
    e_bv = (g >= 0); e_fl = 0; e_fd = '0; e_bo = 0; e_bl = 0; e_bc = 0;
    if (g >= 0) begin
      o = 1 - g; ln = sl[g];
      e_bo = g; e_bl = ln; e_bc = sw[g];
      if (!sw[g]) begin
        fetched = mmem[ln];
        if (mst[o][ln] == 2) begin
          e_fl = 1; e_fd = mdat[o][ln]; mmem[ln] = e_fd; mst[o][ln] = 1; fetched = e_fd;
        end
        mst[g][ln] = 1; mdat[g][ln] = fetched; e_rd[g] = fetched;
      end else begin
        mst[o][ln] = 0; mst[g][ln] = 2; mdat[g][ln] = sd[g];
      end
      e_done[g] = 1; mrr = o;
    end
    for (int k = 0; k < 2; k++) begin
      if (sv[k] && k != g) begin
        ln = sl[k];
        if (sw[k] ? mst[k][ln] == 2 : mst[k][ln] != 0) begin
          e_done[k] = 1;
          if (sw[k]) mdat[k][ln] = sd[k];
          else e_rd[k] = mdat[k][ln];
        end
      end
    end
    for (int k = 0; k < 2; k++) begin
      chk("R8", "done", int'(req_done[k]), int'(e_done[k]));
      if (e_done[k] && !sw[k]) chk("R2", "read data", int'(rd_data[k*DW +: DW]), int'(e_rd[k]));
    end
    chk("R9", "bus valid", int'(bus_valid), int'(e_bv));
    if (e_bv) begin
      chk("R9", "bus owner", int'(bus_owner), e_bo);
      chk("R4", "bus cmd", int'(bus_cmd), int'(e_bc));
      chk("R9", "bus line", int'(bus_line), e_bl);
    end
    chk("R7", "flush", int'(flush), int'(e_fl));
    if (e_fl) begin
      chk("R7", "flush data", int'(flush_data), int'(e_fd));
      chk("R7", "flush line", int'(flush_line), e_bl);
    end
    for (int k = 0; k < 2; k++) if (e_done[k]) sv[k] = 0;
  endtask

  task automatic run_idle();
    while (sv[0] || sv[1]) step();
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int l = 0; l < NL; l++) begin mst[c][l] = 0; mdat[c][l] = '0; end
    for (int l = 0; l < NL; l++) mmem[l] = '0;
    sv[0] = 0; sv[1] = 0; sw[0] = 0; sw[1] = 0; sl[0] = 0; sl[1] = 0; sd[0] = '0; sd[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1", "reset states", int'(line_state), 0);
    chk("R1", "reset no bus", int'(bus_valid), 0);

    issue(0, 0, 0, 8'h00); step();                    // R2 read miss
    chk("R2", "fetch cmd", int'({bus_valid, bus_cmd}), 2);
    issue(0, 0, 0, 8'h00); step();                    // R3 read hit
    chk("R3", "shared read no bus", int'({bus_valid, req_done[0]}), 1);
    issue(1, 1, 0, 8'h5A); step();                    // R4 write upgrade
    chk("R4", "inval by cache1", int'({bus_valid, bus_cmd, bus_owner}), 7);
    step();
    chk("R6", "cache0 invalidated", st_dut(0, 0), 0);
    chk("R4", "cache1 dirty", st_dut(1, 0), 2);
    issue(1, 1, 0, 8'h66); step();                    // R5 dirty write hit
    chk("R5", "dirty write no bus", int'({bus_valid, req_done[1]}), 1);
    issue(0, 0, 0, 8'h00); step();                    // R7 flush on remote read
    chk("R7", "flush word", int'({flush, flush_data}), 'h166);
    chk("R2", "fill from flush", int'(rd_data[DW-1:0]), 'h66);
    step();
    chk("R7", "both shared", st_dut(0, 0) * 4 + st_dut(1, 0), 5);

    issue(0, 0, 1, 8'h00); issue(1, 0, 1, 8'h00); step();   // R9 contention
    chk("R9", "cache1 preferred", int'({bus_owner, req_done}), 6);
    step();
    chk("R9", "cache0 next", int'({bus_valid, bus_owner}), 2);

    issue(0, 1, 1, 8'h11); issue(1, 0, 1, 8'h00); step();   // R8 snoop kills hit
    chk("R8", "shared hit lost", int'(req_done), 1);
    step();
    chk("R8", "refetch flushes", int'({flush, rd_data[2*DW-1:DW]}), 'h111);
    run_idle();

    issue(0, 1, 2, 8'h21); run_idle();
    issue(0, 1, 2, 8'h22); issue(1, 1, 2, 8'h23); step();   // R8 dirty hit lost
    chk("R8", "dirty write lost", int'(req_done), 2);
    run_idle();
    step();
    chk("R6", "cache1 invalid", st_dut(1, 2), 0);

    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < 2; k++)
        if (!sv[k] && $urandom_range(0, 3) != 0)
          issue(k, bit'($urandom_range(0, 1)), int'($urandom_range(0, NL-1)), DW'($urandom));
      step();
    end
    run_idle();
    step();

    done_run = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule